// File: doc/BRIEF.md
# Clocked Serial Master Transmitter

This block sends data words out over a three-wire clocked serial link, with the block acting as the clock master. It produces a serial clock and a serial data line from the system clock. The serial clock rate comes from a power-of-two prescaler followed by a programmable half-period divider. The host reaches the block through a two-register write port. One register holds the mode and timing controls. The other is a one-word transmit buffer.

The controls select five things: the bit order, a short frame (one bit fewer than the full word) or a full-word frame, the edge on which data is launched relative to the sampling edge, whether the first data bit appears half a clock early, and how the interrupt behaves. In single-transfer mode the interrupt pulses when a frame has fully left the shifter. In continuous mode the interrupt pulses each time the buffer hands its word to the shifter. Software can then refill the buffer while the current frame is still shifting, so consecutive frames follow each other with no idle cycle.

Top module: `csi_tx_master`

## Requirements
- R1: After reset, sck is 1, sdo is 0, and busy, buf_full and irq are all 0.
- R2: Each sample edge of sck is a rising edge when polarity is 0 and a falling edge when polarity is 1. At each sample edge, sdo carries the frame bit due at that edge, and sdo never changes on a sample edge.
- R3: The control bit at wr_data[14] picks the frame length. When it is 1, a frame carries DATA_W-1 bits (the low bits of the word). When it is 0, a frame carries DATA_W bits. A frame has exactly that many sample edges and twice that many sck edges.
- R4: The control bit at wr_data[13] picks the bit order. When it is 1, the lowest bit goes first. When it is 0, the highest bit of the frame goes first.
- R5: While the block is idle, sck rests at NOT(polarity XOR phase), where polarity is wr_data[12] and phase is wr_data[11]. After every frame, sck returns to that level.
- R6: With phase 1, sdo already carries the first frame bit before the first sck edge. With phase 0, sdo keeps its previous value until the first sck edge.
- R7: One half period of sck lasts 2^P × (max(D,1)+1) system cycles, where P is wr_data[10:7] and D is wr_data[6:0]. A divider of 0 therefore acts as 1. A single frame keeps busy high for 2·N half periods, starting on the cycle after the data write, where N is the frame length in bits.
- R8: In single-transfer mode (wr_data[15]=0), irq pulses for one cycle. The pulse comes in the same cycle that busy falls at the end of the frame.
- R9: In continuous mode (wr_data[15]=1), irq pulses for one cycle each time the buffer word moves into the shifter. A word buffered before a frame ends starts the next frame with busy staying high throughout. No pulse comes when the last frame ends.
- R10: A control write (wr_sel=0) takes effect only while the block is idle with the buffer empty. A data write (wr_sel=1) is dropped while the buffer is full, and is also dropped in single-transfer mode while busy.
- R11: After a frame, sdo holds the last bit sent until the next frame drives a new bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the transmit buffer |
| wr_data | input | CFG_W | Write data. The buffer takes the low DATA_W bits |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | A frame is in progress |
| buf_full | output | 1 | The transmit buffer holds a word not yet moved to the shifter |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit word, a 7-bit divider and a 4-bit prescaler exponent. Prescaler exponents of 0 to 2 and divider values of 0 to 2 keep each frame down to a few hundred cycles. These settings still cover the clamped zero divider and half periods of 2, 6 and 8 cycles. With the full word width, both frame lengths can be run against every combination of polarity, phase and bit order. Continuous mode is run with a refill during the first frame and a second refill attempt that must be dropped.

// File: rtl/csi_tx_pkg.sv
package csi_tx_pkg;

  localparam int unsigned CSI_DATA_W = 8;
  localparam int unsigned CSI_DIV_W  = 7;
  localparam int unsigned CSI_PRE_W  = 4;
  localparam int unsigned CSI_MODE_W = 5;

  // packed so that the first member lands on the highest control bit
  typedef struct packed {
    logic cont;       // continuous mode: irq on buffer hand-off
    logic len_short;  // frame of DATA_W-1 bits
    logic lsb_first;  // lowest bit leaves first
    logic pol;        // sample on falling edge when set
    logic phase;      // first bit half a clock early when set
  } csi_mode_t;

  // a divider setting of zero behaves as one
  function automatic int unsigned eff_div(input int unsigned d);
    return (d == 0) ? 1 : d;
  endfunction

  // system cycles in one half period of the serial clock
  function automatic int unsigned half_cycles(input int unsigned pre, input int unsigned d);
    return (32'd1 << pre) * (eff_div(d) + 1);
  endfunction

  // resting level of the serial clock
  function automatic logic idle_level(input logic pol, input logic phase);
    return ~(pol ^ phase);
  endfunction

endpackage

// File: rtl/csi_tx_baud.sv
module csi_tx_baud
  import csi_tx_pkg::*;
#(
  parameter int unsigned PRE_W = CSI_PRE_W,
  parameter int unsigned DIV_W = CSI_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre_sel,
  input  logic [DIV_W-1:0] div_sel,
  output logic             half_tick
);

  localparam int unsigned PCW = (1 << PRE_W) - 1;

  logic [PCW-1:0]   pre_cnt;
  logic [PCW-1:0]   pre_lim;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_eff;
  logic             pre_tick;

  assign pre_lim   = (PCW'(1) << pre_sel) - PCW'(1);
  assign pre_tick  = (pre_cnt == pre_lim);
  assign div_eff   = (div_sel == '0) ? DIV_W'(1) : div_sel;
  assign half_tick = run && pre_tick && (div_cnt == div_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (restart || !run) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_tick) begin
      pre_cnt <= '0;
      div_cnt <= half_tick ? '0 : div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // spacing counter used only by the checks below
  logic [31:0] gap_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           gap_cnt <= '0;
    else if (restart || !run || half_tick) gap_cnt <= '0;
    else                                  gap_cnt <= gap_cnt + 32'd1;
  end

  // R7: every half period spans the computed number of cycles
  a_r7_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> (gap_cnt + 32'd1) == 32'(half_cycles(int'(pre_sel), int'(div_sel))));

  // R7: half periods never shrink to a single cycle
  a_r7_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> !half_tick);

endmodule

// File: rtl/csi_tx_shifter.sv
module csi_tx_shifter
  import csi_tx_pkg::*;
#(
  parameter int unsigned DATA_W = CSI_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              phase,
  input  logic              pol,
  input  logic              lsb_first,
  input  logic              len_short,
  input  logic              half_tick,
  output logic              sck,
  output logic              sdo,
  output logic              active,
  output logic              frame_end,
  output logic              sample_evt,
  output logic              drive_evt
);

  localparam int unsigned EW = $clog2(2 * DATA_W);

  // place the word so that the next bit to send always sits at the top
  function automatic logic [DATA_W-1:0] align_word(input logic [DATA_W-1:0] d,
                                                   input logic lsb, input logic shrt);
    logic [DATA_W-1:0] r;
    r = d;
    if (lsb) begin
      for (int i = 0; i < DATA_W; i++) r[DATA_W-1-i] = d[i];
    end else if (shrt) begin
      r = {d[DATA_W-2:0], 1'b0};
    end
    return r;
  endfunction

  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] aligned;
  logic [EW-1:0]     ecnt_q;
  logic [EW-1:0]     last_idx;
  logic              tgl_q;
  logic              sdo_q;
  logic              act_q;
  logic              edge_evt;

  assign aligned    = align_word(load_data, lsb_first, len_short);
  assign last_idx   = len_short ? EW'(2 * DATA_W - 3) : EW'(2 * DATA_W - 1);
  assign edge_evt   = act_q && half_tick;
  assign drive_evt  = edge_evt && (ecnt_q[0] == phase) && (ecnt_q != last_idx);
  assign sample_evt = edge_evt && (ecnt_q[0] != phase);
  assign frame_end  = edge_evt && (ecnt_q == last_idx);

  assign sck    = tgl_q ^ idle_level(pol, phase);
  assign sdo    = sdo_q;
  assign active = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      ecnt_q <= '0;
      tgl_q  <= 1'b0;
      sdo_q  <= 1'b0;
      act_q  <= 1'b0;
    end else if (load) begin
      act_q  <= 1'b1;
      ecnt_q <= '0;
      tgl_q  <= 1'b0;
      if (phase) begin
        sdo_q <= aligned[DATA_W-1];
        sh_q  <= {aligned[DATA_W-2:0], 1'b0};
      end else begin
        sh_q  <= aligned;
      end
    end else if (edge_evt) begin
      tgl_q  <= ~tgl_q;
      ecnt_q <= ecnt_q + 1'b1;
      if (frame_end) act_q <= 1'b0;
      if (drive_evt) begin
        sdo_q <= sh_q[DATA_W-1];
        sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  // R2: data is steady across a sampling edge
  a_r2_sdo_steady: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> $stable(sdo_q));

  // R3: the edge count never passes the frame's last edge
  a_r3_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> ecnt_q <= last_idx);

  // R5: an even number of edges brings the clock home
  a_r5_clock_home: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !load) |=> !tgl_q);

  // R11: an idle shifter leaves the data line alone
  a_r11_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && $past(!act_q)) |-> $stable(sdo_q));

endmodule

// File: rtl/csi_tx_master.sv
module csi_tx_master
  import csi_tx_pkg::*;
#(
  parameter int unsigned DATA_W = CSI_DATA_W,
  parameter int unsigned DIV_W  = CSI_DIV_W,
  parameter int unsigned PRE_W  = CSI_PRE_W,
  parameter int unsigned CFG_W  = DIV_W + PRE_W + CSI_MODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CFG_W-1:0] wr_data,
  output logic             sck,
  output logic             sdo,
  output logic             busy,
  output logic             buf_full,
  output logic             irq
);

  localparam int unsigned PRE_LSB  = DIV_W;
  localparam int unsigned MODE_LSB = DIV_W + PRE_W;

  logic [DIV_W-1:0]  div_q;
  logic [PRE_W-1:0]  pre_q;
  csi_mode_t         mode_q;
  logic [DATA_W-1:0] buf_q;
  logic              buf_full_q;
  logic              busy_q;
  logic              irq_q;

  // named internal events
  logic cfg_wr;
  logic data_wr;
  logic load;
  logic irq_set;
  logic half_tick;
  logic frame_end;
  logic sample_evt;
  logic drive_evt;
  logic active;

  assign cfg_wr  = wr_en && !wr_sel && !busy_q && !buf_full_q;
  assign data_wr = wr_en && wr_sel && !buf_full_q && (mode_q.cont || !busy_q);
  assign load    = buf_full_q && (!busy_q || (mode_q.cont && frame_end));
  assign irq_set = mode_q.cont ? load : frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      pre_q  <= '0;
      mode_q <= '0;
    end else if (cfg_wr) begin
      div_q  <= wr_data[DIV_W-1:0];
      pre_q  <= wr_data[PRE_LSB +: PRE_W];
      mode_q <= csi_mode_t'(wr_data[MODE_LSB +: CSI_MODE_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q      <= '0;
      buf_full_q <= 1'b0;
      busy_q     <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (data_wr) begin
        buf_q      <= wr_data[DATA_W-1:0];
        buf_full_q <= 1'b1;
      end else if (load) begin
        buf_full_q <= 1'b0;
      end
      if (load)           busy_q <= 1'b1;
      else if (frame_end) busy_q <= 1'b0;
      irq_q <= irq_set;
    end
  end

  csi_tx_baud #(
    .PRE_W (PRE_W),
    .DIV_W (DIV_W)
  ) baud_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy_q),
    .restart   (load),
    .pre_sel   (pre_q),
    .div_sel   (div_q),
    .half_tick (half_tick)
  );

  csi_tx_shifter #(
    .DATA_W (DATA_W)
  ) shift_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_data  (buf_q),
    .phase      (mode_q.phase),
    .pol        (mode_q.pol),
    .lsb_first  (mode_q.lsb_first),
    .len_short  (mode_q.len_short),
    .half_tick  (half_tick),
    .sck        (sck),
    .sdo        (sdo),
    .active     (active),
    .frame_end  (frame_end),
    .sample_evt (sample_evt),
    .drive_evt  (drive_evt)
  );

  assign busy     = busy_q;
  assign buf_full = buf_full_q;
  assign irq      = irq_q;

  // R2: shifting happens only inside a frame
  a_r2_events_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt || drive_evt) |-> busy_q);

  // R5: an idle block rests the clock at its home level
  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sck == idle_level(mode_q.pol, mode_q.phase));

  // R7: the shifter and the frame flag agree
  a_r7_active_busy: assert property (@(posedge clk) disable iff (!rst_n)
    active == busy_q);

  // R8: in single-transfer mode the pulse arrives as the frame closes
  a_r8_single_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !mode_q.cont) |-> !busy_q);

  // R9: the interrupt is a one-cycle pulse
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R10: controls stay put for the whole frame
  a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable({div_q, pre_q, mode_q}));

endmodule

// File: tb/csi_tx_master_tb_top.sv
module csi_tx_master_tb_top;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned CFG_W  = 16;
  localparam int NVEC = 6;
  // {control word, data word}
  localparam logic [23:0] VEC [NVEC] = '{
    {16'h0001, 8'hA5},   // pol0 ph0 msb full, H=2
    {16'h1001, 8'h3C},   // pol1
    {16'h0801, 8'h96},   // phase1
    {16'h6001, 8'h5B},   // lsb first, short frame
    {16'h3882, 8'hC3},   // pol1 ph1 lsb, pre 1 div 2, H=6
    {16'h4100, 8'h71}    // short msb, pre 2 div 0 -> clamp, H=8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [CFG_W-1:0] wr_data = '0;
  logic sck, sdo, busy, buf_full, irq;
  int checks = 0;
  int fails = 0;

  csi_tx_master dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sck(sck), .sdo(sdo), .busy(busy), .buf_full(buf_full), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int hcyc(input logic [15:0] c);
    int d;
    d = int'(c[6:0]);
    if (d == 0) d = 1;
    return (1 << c[10:7]) * (d + 1);
  endfunction

  function automatic int nbits(input logic [15:0] c);
    return c[14] ? 7 : 8;
  endfunction

  function automatic logic ebit(input logic [7:0] d, input logic [15:0] c, input int i);
    return c[13] ? d[i] : d[nbits(c) - 1 - i];
  endfunction

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // follows one busy period; optional writes are injected at given busy counts
  task automatic mon(input logic [15:0] cfg, input logic [7:0] d0, input logic [7:0] d1,
                     input int inj_at, input logic s1, input logic [15:0] v1,
                     input logic s2, input logic [15:0] v2, input bit chk_buf,
                     output int busy_cyc, output int nsamp, output int nirq,
                     output bit irq_end, output int nedges);
    logic p_sck, p_sdo, s_sdo, pol, ph, eb;
    bit seen;
    int guard, n;
    p_sck = sck; p_sdo = sdo; s_sdo = sdo;
    pol = cfg[12]; ph = cfg[11]; n = nbits(cfg);
    seen = 0; guard = 0;
    busy_cyc = 0; nsamp = 0; nirq = 0; irq_end = 0; nedges = 0;
    while (guard < 20000) begin
      @(negedge clk);
      guard++;
      if (busy) begin seen = 1; busy_cyc++; end
      if (irq) nirq++;
      if (inj_at > 0 && busy) begin
        if (busy_cyc == inj_at) begin
          wr_en = 1'b1; wr_sel = s1; wr_data = v1;
        end else if (busy_cyc == inj_at + 1) begin
          wr_sel = s2; wr_data = v2;
        end else if (busy_cyc == inj_at + 2) begin
          wr_en = 1'b0;
          if (chk_buf) check(buf_full == 1'b1, "R9", "buffer flag after refill", int'(buf_full), 1);
        end
      end
      if (sck != p_sck) begin
        nedges++;
        if (nedges == 1)
          check(p_sdo == (ph ? ebit(d0, cfg, 0) : s_sdo), "R6", "sdo before first edge",
                int'(p_sdo), int'(ph ? ebit(d0, cfg, 0) : s_sdo));
        if ((!pol && sck) || (pol && !sck)) begin
          eb = ebit((nsamp < n) ? d0 : d1, cfg, nsamp % n);
          check(sdo == eb, "R2 R4", "bit at sample edge", int'(sdo), int'(eb));
          check(sdo == p_sdo, "R2", "sdo moved on sample edge", int'(sdo), int'(p_sdo));
          nsamp++;
        end
      end
      p_sck = sck; p_sdo = sdo;
      if (seen && !busy) begin irq_end = irq; break; end
    end
    if (!seen || guard >= 20000) check(1'b0, "R7", "frame did not finish", guard, 0);
  endtask

  task automatic run_frame(input logic [15:0] cfg, input logic [7:0] d,
                           input int inj_at, input logic s1, input logic [15:0] v1,
                           input logic s2, input logic [15:0] v2);
    int bc, ns, ni, ne, n, h;
    bit ie;
    logic last;
    n = nbits(cfg); h = hcyc(cfg);
    wr(1'b0, cfg);
    wr(1'b1, {8'h00, d});
    mon(cfg, d, d, inj_at, s1, v1, s2, v2, 1'b0, bc, ns, ni, ie, ne);
    check(ns == n, "R3", "sample edges", ns, n);
    check(ne == 2 * n, "R3", "clock edges", ne, 2 * n);
    check(bc == 2 * n * h, "R7", "busy cycles", bc, 2 * n * h);
    check(ie && ni == 1, "R8", "irq at frame end", ni, 1);
    check(sck == ~(cfg[12] ^ cfg[11]), "R5", "idle clock level", int'(sck), int'(~(cfg[12] ^ cfg[11])));
    last = ebit(d, cfg, n - 1);
    check(sdo == last, "R11", "sdo after frame", int'(sdo), int'(last));
    repeat (5) @(negedge clk);
    check(sdo == last, "R11", "sdo held while idle", int'(sdo), int'(last));
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int bc, ns, ni, ne;
    bit ie;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(sck == 1'b1, "R1", "sck", int'(sck), 1);
    check(sdo == 1'b0, "R1", "sdo", int'(sdo), 0);
    check(busy == 1'b0, "R1", "busy", int'(busy), 0);
    check(buf_full == 1'b0, "R1", "buf_full", int'(buf_full), 0);
    check(irq == 1'b0, "R1", "irq", int'(irq), 0);

    for (int k = 0; k < NVEC; k++)
      run_frame(VEC[k][23:8], VEC[k][7:0], 0, 1'b0, 16'h0, 1'b0, 16'h0);

    // R10: control and data writes during a single-mode frame are dropped
    run_frame(16'h0001, 8'h0F, 3, 1'b0, 16'h1001, 1'b1, 16'h0055);
    repeat (20) @(negedge clk);
    check(busy == 1'b0, "R10", "dropped data write started a frame", int'(busy), 0);
    check(sck == 1'b1, "R10", "dropped control write changed idle level", int'(sck), 1);

    // R9: continuous mode, refill during first frame, extra write dropped
    wr(1'b0, 16'h8001);
    wr(1'b1, 16'h00A5);
    mon(16'h8001, 8'hA5, 8'h3C, 2, 1'b1, 16'h003C, 1'b1, 16'h00FF, 1'b1, bc, ns, ni, ie, ne);
    check(ns == 16, "R9", "samples over two frames", ns, 16);
    check(bc == 64, "R9", "busy cycles without gap", bc, 64);
    check(ni == 2, "R9", "irq pulses", ni, 2);
    check(ie == 1'b0, "R9", "irq at last frame end", int'(ie), 0);
    check(buf_full == 1'b0, "R9", "buffer drained", int'(buf_full), 0);
    check(sdo == 1'b0, "R11", "last bit of second word", int'(sdo), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule